// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block gathers a parameterised set of interrupt lines from peripherals and steers each of them to exactly one of a small number of processor cores. Every source line is configured on its own: it can be level sensitive or edge sensitive, active high or active low, and an edge source can also be made to react to both transitions. A source only counts toward a core's request when it is enabled in the mask, routed to that core and given a valid output pin mapping.

Software reaches the block through a flat 32-bit register port. Masks are changed through two write-only words, one that only enables and one that only disables, so no read-modify-write is needed to change a single source. A command word sets or clears the edge latch of any one source, which lets one core raise an interrupt on another. Each core receives a registered request line, together with the index and pin number of the lowest-numbered source that is currently asking for it.

The register address is split into a 4-bit region (address bits 11:8) and an 8-bit index (bits 7:0). Word regions use the index as a word number covering sources 32*index to 32*index+31; per-source regions use it as a source number. Regions: 0 control (index 0 configuration, index 1 edge command), 1 polarity, 2 trigger, 3 dual edge, 4 enable-mask write (reads mask), 5 disable-mask write (reads mask), 6 raw pending, 7 mask, 8 pin map, 9 core route, 10 per-core pending (index = core*words + word).

Top module: `shared_irq_router`

## Requirements
- R1: After reset every source has polarity 1 (active high / rising), trigger 0 (level), dual edge 0, mask 0, route to core 0 and an invalid pin map; all core outputs are 0.
- R2: A write to region 4 enables every source whose data bit is 1 and leaves sources whose bit is 0 unchanged; reading region 4 or 7 returns the mask.
- R3: A write to region 5 disables every source whose data bit is 1 and leaves sources whose bit is 0 unchanged.
- R4: A level source (trigger 0) has its raw pending bit equal to the input when polarity is 1 and to the inverted input when polarity is 0; edge commands do not change it.
- R5: An edge source (trigger 1, dual 0) latches pending on a rising input when polarity is 1 and on a falling input when polarity is 0, and holds it after the input returns.
- R6: With dual edge set (bit in region 3 is 1) an edge source latches on both transitions, regardless of polarity.
- R7: Writing the edge command word (region 0, index 1) with bit 31 = 1 sets, and with bit 31 = 0 clears, the edge latch of the source numbered in bits 7:0; an index not below the source count, or a level source, is left unaffected.
- R8: A route write (region 9) selects the lowest set bit of the data's core field as the single target core and reads back as that one-hot value; a write with no core bit set is ignored.
- R9: The per-core pending word (region 10) is raw pending AND mask AND the sources routed to that core.
- R10: Each core request is the OR of that core's pending bits whose pin map is valid, registered one clock later; core_src and core_pin carry the lowest such source index and its pin (0 when none).
- R11: The configuration word (region 0, index 0) reads (core count - 1) in bits 23:16 and (source count / 8 - 1) in bits 7:0.
- R12: A pin map write (region 8) stores bit 31 as the valid flag and the low bits as the pin number, and reads back the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Interrupt source lines, synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register address: region in 11:8, index in 7:0 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| core_irq | output | NUM_CORE | Registered interrupt request per core |
| core_src | output | NUM_CORE*SRC_W | Lowest requesting source index per core |
| core_pin | output | NUM_CORE*PIN_W | Pin number of that source per core |

## Verification
Directed cases drive single sources through each trigger style in isolation: a level source held at both polarities, a single-edge source pulsed against its active and inactive direction, and a dual-edge source moved both ways, which separates a latch from a follower and polarity sensitivity from its absence. Software set and clear commands are applied to level and out-of-range sources to show they are ignored, and a one-cycle timing probe shows the core request appears exactly one edge after the pending condition. Random sequences then mix input toggles, configuration rewrites, mask edits, reroutes and pin map changes, so that routing and masking interact with latched edges and the lowest-index selection is exercised with several competing sources.

// File: rtl/shared_irq_router.sv
module shared_irq_router #(
  parameter int NUM_SRC  = 16,
  parameter int NUM_CORE = 2,
  parameter int NUM_PIN  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            src_in,
  input  logic                          reg_we,
  input  logic [11:0]                   reg_addr,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  output logic [NUM_CORE-1:0]           core_irq,
  output logic [NUM_CORE*$clog2(NUM_SRC)-1:0] core_src,
  output logic [NUM_CORE*((NUM_PIN > 1) ? $clog2(NUM_PIN) : 1)-1:0] core_pin
);
  localparam int SRC_W  = $clog2(NUM_SRC);
  localparam int PIN_W  = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1;
  localparam int CORE_W = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1;
  localparam int NWORD  = (NUM_SRC + 31) / 32;
  localparam logic [31:0] CFG_WORD = (32'(NUM_CORE - 1) << 16) | 32'(NUM_SRC / 8 - 1);

  localparam logic [3:0] RG_CTL   = 4'd0;
  localparam logic [3:0] RG_POL   = 4'd1;
  localparam logic [3:0] RG_TRIG  = 4'd2;
  localparam logic [3:0] RG_DUAL  = 4'd3;
  localparam logic [3:0] RG_MSET  = 4'd4;
  localparam logic [3:0] RG_MCLR  = 4'd5;
  localparam logic [3:0] RG_RAW   = 4'd6;
  localparam logic [3:0] RG_MASK  = 4'd7;
  localparam logic [3:0] RG_PMAP  = 4'd8;
  localparam logic [3:0] RG_ROUTE = 4'd9;
  localparam logic [3:0] RG_CPEND = 4'd10;

  logic [NUM_SRC-1:0] pol_q, trig_q, dual_q, mask_q, lat_q, prev_q;
  logic [NUM_SRC-1:0] lat_d, act, rise, fall, hit, raw, map_v_q;
  logic [CORE_W-1:0]  route_q   [NUM_SRC];
  logic [PIN_W-1:0]   map_pin_q [NUM_SRC];
  logic [NUM_SRC-1:0] cpend     [NUM_CORE];
  logic [NUM_SRC-1:0] elig      [NUM_CORE];
  logic [SRC_W-1:0]   low_idx   [NUM_CORE];
  logic [PIN_W-1:0]   low_pin   [NUM_CORE];
  logic [NUM_SRC-1:0] wvec;
  logic [CORE_W-1:0]  rt_sel;
  logic               rt_ok;

  wire [3:0] rg    = reg_addr[11:8];
  wire [7:0] ix    = reg_addr[7:0];
  wire       ecmd  = reg_we && rg == RG_CTL && ix == 8'd1;
  wire       e_set = reg_wdata[31];
  wire [7:0] e_idx = reg_wdata[7:0];

  assign act  = ~(src_in ^ pol_q);
  assign rise = src_in & ~prev_q;
  assign fall = ~src_in & prev_q;
  assign hit  = (dual_q & (rise | fall)) | (~dual_q & ((pol_q & rise) | (~pol_q & fall)));
  assign raw  = (trig_q & lat_q) | (~trig_q & act);

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      lat_d[i] = lat_q[i];
      if (!trig_q[i])
        lat_d[i] = 1'b0;
      else if (hit[i] || (ecmd && e_set && e_idx == 8'(i)))
        lat_d[i] = 1'b1;
      else if (ecmd && !e_set && e_idx == 8'(i))
        lat_d[i] = 1'b0;
    end
  end

  always_comb begin
    rt_ok  = 1'b0;
    rt_sel = '0;
    for (int c = NUM_CORE - 1; c >= 0; c--) begin
      if (reg_wdata[c]) begin
        rt_ok  = 1'b1;
        rt_sel = CORE_W'(c);
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CORE; c++) begin
      low_idx[c] = '0;
      low_pin[c] = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        cpend[c][i] = raw[i] & mask_q[i] & (route_q[i] == CORE_W'(c));
        elig[c][i]  = cpend[c][i] & map_v_q[i];
      end
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
        if (elig[c][i]) begin
          low_idx[c] = SRC_W'(i);
          low_pin[c] = map_pin_q[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q    <= '1;
      trig_q   <= '0;
      dual_q   <= '0;
      mask_q   <= '0;
      lat_q    <= '0;
      prev_q   <= '0;
      map_v_q  <= '0;
      core_irq <= '0;
      core_src <= '0;
      core_pin <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        route_q[i]   <= '0;
        map_pin_q[i] <= '0;
      end
    end else begin
      prev_q <= src_in;
      lat_q  <= lat_d;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (reg_we && ix == 8'(i / 32)) begin
          case (rg)
            RG_POL:  pol_q[i]  <= reg_wdata[i % 32];
            RG_TRIG: trig_q[i] <= reg_wdata[i % 32];
            RG_DUAL: dual_q[i] <= reg_wdata[i % 32];
            RG_MSET: if (reg_wdata[i % 32]) mask_q[i] <= 1'b1;
            RG_MCLR: if (reg_wdata[i % 32]) mask_q[i] <= 1'b0;
            default: ;
          endcase
        end
        if (reg_we && ix == 8'(i)) begin
          if (rg == RG_PMAP) begin
            map_v_q[i]   <= reg_wdata[31];
            map_pin_q[i] <= reg_wdata[PIN_W-1:0];
          end
          if (rg == RG_ROUTE && rt_ok)
            route_q[i] <= rt_sel;
        end
      end
      for (int c = 0; c < NUM_CORE; c++) begin
        core_irq[c]                  <= |elig[c];
        core_src[c*SRC_W +: SRC_W]   <= low_idx[c];
        core_pin[c*PIN_W +: PIN_W]   <= low_pin[c];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (rg)
      RG_POL:           wvec = pol_q;
      RG_TRIG:          wvec = trig_q;
      RG_DUAL:          wvec = dual_q;
      RG_RAW:           wvec = raw;
      RG_MSET, RG_MCLR,
      RG_MASK:          wvec = mask_q;
      default:          wvec = '0;
    endcase
    case (rg)
      RG_CTL:
        if (ix == 8'd0) reg_rdata = CFG_WORD;
      RG_POL, RG_TRIG, RG_DUAL, RG_RAW, RG_MSET, RG_MCLR, RG_MASK:
        for (int i = 0; i < NUM_SRC; i++)
          if (ix == 8'(i / 32)) reg_rdata[i % 32] = wvec[i];
      RG_PMAP:
        for (int i = 0; i < NUM_SRC; i++)
          if (ix == 8'(i)) reg_rdata = {map_v_q[i], {(31 - PIN_W){1'b0}}, map_pin_q[i]};
      RG_ROUTE:
        for (int i = 0; i < NUM_SRC; i++)
          if (ix == 8'(i)) reg_rdata = 32'd1 << route_q[i];
      RG_CPEND:
        for (int c = 0; c < NUM_CORE; c++)
          for (int i = 0; i < NUM_SRC; i++)
            if (ix == 8'(c * NWORD + i / 32)) reg_rdata[i % 32] = cpend[c][i];
      default: ;
    endcase
  end
endmodule

// File: rtl/shared_irq_router_chk.sv
module shared_irq_router_chk #(
  parameter int NUM_SRC  = 16,
  parameter int NUM_CORE = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_we,
  input logic [11:0]         reg_addr,
  input logic [31:0]         reg_wdata,
  input logic [31:0]         reg_rdata,
  input logic [NUM_CORE-1:0] core_irq,
  input logic [NUM_SRC-1:0]  mask_q,
  input logic [NUM_SRC-1:0]  trig_q,
  input logic [NUM_SRC-1:0]  lat_q,
  input logic [NUM_SRC-1:0]  hit
);
  localparam int SRC_W = $clog2(NUM_SRC);
  localparam int LW    = (NUM_SRC < 32) ? NUM_SRC : 32;
  localparam logic [31:0] CFG_EXP = (32'(NUM_CORE - 1) << 16) | 32'(NUM_SRC / 8 - 1);

  wire             mset   = reg_we && reg_addr == 12'h400;
  wire             mclr   = reg_we && reg_addr == 12'h500;
  wire             mwr    = reg_we && (reg_addr[11:8] == 4'd4 || reg_addr[11:8] == 4'd5);
  wire             ecmd   = reg_we && reg_addr == 12'h001;
  wire             eok    = reg_wdata[7:0] < 8'(NUM_SRC);
  wire [SRC_W-1:0] eidx   = reg_wdata[SRC_W-1:0];
  wire [LW-1:0]    wbits  = reg_wdata[LW-1:0];

  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mwr |=> $stable(mask_q));

  assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mset |=> ((mask_q[LW-1:0] & $past(wbits)) == $past(wbits)));

  assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> ((mask_q[LW-1:0] & $past(wbits)) == '0));

  assert_level_no_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat_q & ~$past(trig_q)) == '0));

  assert_cmd_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ecmd && reg_wdata[31] && eok && trig_q[eidx]) |=> lat_q[$past(eidx)]);

  assert_cmd_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ecmd && !reg_wdata[31] && eok && !hit[eidx]) |=> !lat_q[$past(eidx)]);

  assert_quiet_when_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> (core_irq == '0));

  assert_cfg_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 12'h000) |-> (reg_rdata == CFG_EXP));
endmodule

bind shared_irq_router shared_irq_router_chk #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .core_irq(core_irq), .mask_q(mask_q), .trig_q(trig_q),
  .lat_q(lat_q), .hit(hit)
);

// File: tb/shared_irq_router_tb_top.sv
module shared_irq_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int NC = 2;

  logic        clk = 0, rst_n = 0;
  logic [NS-1:0] src_in = '0;
  logic        reg_we = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NC-1:0] core_irq;
  logic [NC*4-1:0] core_src;
  logic [NC*3-1:0] core_pin;

  int n_chk = 0, n_fail = 0;

  logic [NS-1:0] m_src = '0, m_pol = '1, m_trig = '0, m_dual = '0, m_mask = '0, m_lat = '0, m_v = '0;
  logic [0:0]    m_route [NS];
  logic [2:0]    m_pin   [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_irq_router #(.NUM_SRC(NS), .NUM_CORE(NC), .NUM_PIN(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_irq(core_irq),
    .core_src(core_src), .core_pin(core_pin));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [NS-1:0] m_raw();
    return (m_trig & m_lat) | (~m_trig & ~(m_src ^ m_pol));
  endfunction

  function automatic logic [NS-1:0] m_cpend(input int c);
    logic [NS-1:0] r = m_raw() & m_mask;
    for (int i = 0; i < NS; i++) if (m_route[i] != 1'(c)) r[i] = 1'b0;
    return r;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
    case (a[11:8])
      4'd0: if (a[7:0] == 8'd1 && d[7:0] < NS && m_trig[d[3:0]]) m_lat[d[3:0]] = d[31];
      4'd1: m_pol = d[NS-1:0];
      4'd2: begin m_trig = d[NS-1:0]; m_lat &= m_trig; end
      4'd3: m_dual = d[NS-1:0];
      4'd4: m_mask |= d[NS-1:0];
      4'd5: m_mask &= ~d[NS-1:0];
      4'd8: begin m_v[a[3:0]] = d[31]; m_pin[a[3:0]] = d[2:0]; end
      4'd9: if (d[0]) m_route[a[3:0]] = 1'b0; else if (d[1]) m_route[a[3:0]] = 1'b1;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic drive_src(input logic [NS-1:0] v);
    logic [NS-1:0] r, f, h;
    @(negedge clk);
    r = v & ~m_src; f = m_src & ~v;
    h = (m_dual & (r | f)) | (~m_dual & ((m_pol & r) | (~m_pol & f)));
    m_lat = (m_lat | h) & m_trig;
    src_in = v; m_src = v;
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    logic [NS-1:0] el;
    int lo; logic [2:0] lp;
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      el = m_cpend(c) & m_v;
      lo = 0; lp = 0;
      for (int i = NS - 1; i >= 0; i--) if (el[i]) begin lo = i; lp = m_pin[i]; end
      chk(core_irq[c] == |el, {tag, " R10 irq"}, 32'(core_irq[c]), 32'(|el));
      chk(core_src[c*4 +: 4] == 4'(lo), {tag, " R10 src"}, 32'(core_src[c*4 +: 4]), 32'(lo));
      chk(core_pin[c*3 +: 3] == lp, {tag, " R10 pin"}, 32'(core_pin[c*3 +: 3]), 32'(lp));
    end
    rd(12'h600, d); chk(d[NS-1:0] == m_raw(), {tag, " R4/R5 raw"}, d, 32'(m_raw()));
    rd(12'h700, d); chk(d[NS-1:0] == m_mask, {tag, " R2/R3 mask"}, d, 32'(m_mask));
    for (int c = 0; c < NC; c++) begin
      rd(12'hA00 | 12'(c), d);
      chk(d[NS-1:0] == m_cpend(c), {tag, " R9 core pend"}, d, 32'(m_cpend(c)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < NS; i++) begin m_route[i] = 0; m_pin[i] = 0; end
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(12'h100, d); chk(d == 32'h0000FFFF, "R1 polarity", d, 32'h0000FFFF);
    rd(12'h200, d); chk(d == 0, "R1 trigger", d, 0);
    rd(12'h300, d); chk(d == 0, "R1 dual", d, 0);
    rd(12'h700, d); chk(d == 0, "R1 mask", d, 0);
    rd(12'h903, d); chk(d == 1, "R1 route", d, 1);
    rd(12'h803, d); chk(d == 0, "R1 pin map", d, 0);
    chk(core_irq == 0, "R1 core_irq", 32'(core_irq), 0);

    // R11
    rd(12'h000, d); chk(d == 32'h00010001, "R11 config", d, 32'h00010001);

    // R2/R3
    wr(12'h400, 32'h00F0); wr(12'h400, 32'h0001);
    rd(12'h400, d); chk(d == 32'h00F1, "R2 set mask", d, 32'h00F1);
    wr(12'h500, 32'h0010);
    rd(12'h500, d); chk(d == 32'h00E1, "R3 clear mask", d, 32'h00E1);

    // R4 level active low on source 5
    wr(12'h100, 32'hFFDF);
    rd(12'h600, d); chk(d[5] == 1, "R4 active low idle", d, 1);
    wr(12'h001, 32'h0000_0005);
    rd(12'h600, d); chk(d[5] == 1, "R4 clear ignored", d, 1);
    drive_src(16'h0020);
    rd(12'h600, d); chk(d[5] == 0, "R4 follows input", d, 0);
    wr(12'h001, 32'h8000_0005);
    rd(12'h600, d); chk(d[5] == 0, "R4 set ignored", d, 0);
    drive_src(16'h0000);

    // R5 single edge on 2 (rising) and 3 (falling)
    wr(12'h100, 32'hFFF7); wr(12'h200, 32'h000C);
    drive_src(16'h0008); drive_src(16'h0000);
    rd(12'h600, d); chk(d[3:2] == 2'b10, "R5 falling latched only", 32'(d[3:2]), 2);
    drive_src(16'h0004); drive_src(16'h0000);
    rd(12'h600, d); chk(d[3:2] == 2'b11, "R5 rising latched held", 32'(d[3:2]), 3);
    wr(12'h001, 32'h2); wr(12'h001, 32'h3);
    rd(12'h600, d); chk(d[3:2] == 0, "R7 clear edge", 32'(d[3:2]), 0);

    // R6 dual edge on 4
    wr(12'h200, 32'h001C); wr(12'h300, 32'h0010);
    drive_src(16'h0010);
    rd(12'h600, d); chk(d[4] == 1, "R6 rise", d, 1);
    wr(12'h001, 32'h4);
    drive_src(16'h0000);
    rd(12'h600, d); chk(d[4] == 1, "R6 fall", d, 1);

    // R7 set command and out-of-range index
    wr(12'h001, 32'h8000_0002);
    rd(12'h600, d); chk(d[2] == 1, "R7 set edge", d, 1);
    wr(12'h001, 32'h8000_00C8);
    rd(12'h600, d); chk(d[NS-1:0] == m_raw(), "R7 bad index ignored", d, 32'(m_raw()));

    // R8 routing
    wr(12'h902, 32'h2);
    rd(12'h902, d); chk(d == 2, "R8 route core1", d, 2);
    wr(12'h902, 32'h0);
    rd(12'h902, d); chk(d == 2, "R8 zero ignored", d, 2);
    wr(12'h906, 32'h3);
    rd(12'h906, d); chk(d == 1, "R8 lowest bit", d, 1);
    check_all("R9 directed");

    // R12 pin map
    wr(12'h807, 32'h8000_0005);
    rd(12'h807, d); chk(d == 32'h8000_0005, "R12 pin map", d, 32'h8000_0005);

    // R10 timing on level source 7
    wr(12'h200, 32'h0); wr(12'h500, 32'hFFFF); wr(12'h400, 32'h0080);
    wr(12'h100, 32'hFFFF);
    @(negedge clk);
    src_in[7] = 1'b1; m_src[7] = 1'b1;
    #1 chk(core_irq[0] == 0, "R10 before edge", 32'(core_irq[0]), 0);
    @(posedge clk); #1;
    chk(core_irq[0] == 1, "R10 after edge", 32'(core_irq[0]), 1);
    chk(core_src[3:0] == 7, "R10 src index", 32'(core_src[3:0]), 7);
    chk(core_pin[2:0] == 5, "R10 pin", 32'(core_pin[2:0]), 5);
    drive_src(16'h0000);
    check_all("R10 directed");

    // random mix
    for (int it = 0; it < 200; it++) begin
      int op = $urandom % 8;
      int s  = $urandom % NS;
      case (op)
        0, 1: drive_src(16'($urandom));
        2: wr(12'h100, 32'($urandom % 65536));
        3: wr(12'h200, 32'($urandom % 65536));
        4: wr(12'h300, 32'($urandom % 65536));
        5: wr(($urandom % 2) ? 12'h400 : 12'h500, 32'($urandom % 65536));
        6: wr(12'h001, {($urandom % 2) == 1, 23'd0, 8'($urandom % 20)});
        default: if ($urandom % 2) wr(12'h900 | 12'(s), 32'($urandom % 4));
                 else wr(12'h800 | 12'(s), {($urandom % 4) != 0, 28'd0, 3'($urandom)});
      endcase
      check_all("random R5/R6/R8/R9");
    end
    finish_run();
  end
endmodule